// File: doc/BRIEF.md
# Coarse-Fine Time-to-Digital Converter

This block time-stamps hit events against a start/reset event. The coarse part of the time stamp counts main-clock cycles since the last start pulse. The fine part divides one clock period into 32 bins, taken from a thermometer-coded snapshot of a delay line with 32 equal taps. An external model supplies that snapshot, already sampled on the clock, together with a one-cycle hit strobe. The result is a 20-bit time word with the 15-bit coarse count in the upper bits and the 5-bit fine code in the lower bits. It is presented with a one-cycle valid strobe and a flag that marks a malformed tap vector.

A hit is asynchronous to the clock, so the count can be ambiguous when the hit lands near a counter transition. To remove that ambiguity, two coarse counters run side by side. The second one trails the first by half a period, and the fine code decides which of the two is reported. The encoder needs one idle cycle after each result. Hits that arrive while a result is pending wait in a one-deep buffer. A sticky flag reports a hit that is lost because the buffer is already full. A second sticky flag reports that the coarse counter has wrapped since the last start.

Top module: `tdc_coarse_fine`

## Requirements
- R1: After reset, `time_o`, `valid_o`, `fine_err_o`, `rollover_o` and `overflow_o` are all zero.
- R2: The primary coarse counter is cleared by the clock edge that samples `start_i` and then advances by one on every edge. For a hit sampled N edges after that start edge, with fine code 16 or above, the coarse field is (N-1) mod 32768. The value used is the one the counter held before the hit edge.
- R3: For a fine code of 15 or below, the coarse field comes from the trailing counter instead. Its value is (N-2) mod 32768, or 0 when N is 1.
- R4: For a clean tap vector that holds k+1 ones from bit 0 upward, with k from 0 to 30, the fine code is k and `fine_err_o` is 0.
- R5: Any other tap vector sets `fine_err_o`. Its code is the lowest index i with tap i = 1 and tap i+1 = 0. If no such index exists, the code is 31 for an all-ones vector and 0 otherwise.
- R6: `time_o` is {coarse[14:0], fine[4:0]}. When the queue is idle, `valid_o` is high for exactly one cycle, starting at the edge after the hit edge.
- R7: The primary counter wraps from 32767 to 0. The edge that wraps it sets `rollover_o`, which stays high until a start pulse.
- R8: A hit that arrives while a result is pending goes into a one-deep buffer. Results leave in arrival order and never on two consecutive cycles. Each result carries the counts captured when its hit arrived.
- R9: A hit that arrives while both the pending stage and the buffer are full is dropped. It sets `overflow_o`, which stays high until a start pulse.
- R10: A start pulse clears both coarse counters, `rollover_o` and `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: clears counters and sticky flags |
| hit_i | input | 1 | One-cycle hit strobe, already in the clock domain |
| taps_i | input | 32 | Thermometer snapshot of the delay-line taps, valid with `hit_i` |
| time_o | output | 20 | Time word {coarse, fine} |
| valid_o | output | 1 | One-cycle strobe marking a new `time_o` |
| fine_err_o | output | 1 | Tap vector of the current result was malformed |
| rollover_o | output | 1 | Coarse counter wrapped since the last start (sticky) |
| overflow_o | output | 1 | A hit was dropped since the last start (sticky) |

## Verification
The interesting collision is between emitting a pending result and accepting a new hit on the same clock edge. That edge decides whether the new hit is buffered, moved up, or dropped. The bench drives hits on four consecutive edges so that emission, buffering and dropping all meet in adjacent cycles. It then checks the order, spacing and captured coarse counts of the three surviving results, confirms that the fourth never appears, and checks that the overflow flag rises on the right edge. Random hits with clean and corrupted tap vectors, spaced so that the queue drains between them, cover the encoder and the counter selection against bench-side reference functions.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int TDC_TAPS = 32;
    localparam int TDC_CW   = 15;
    localparam int TDC_FW   = $clog2(TDC_TAPS);

    typedef struct packed {
        logic [TDC_TAPS-1:0] taps;
        logic [TDC_CW-1:0]   prim;
        logic [TDC_CW-1:0]   half;
    } hit_rec_t;

    typedef struct packed {
        logic [TDC_CW+TDC_FW-1:0] tword;
        logic                     valid;
        logic                     err;
    } result_t;
endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr
    import tdc_pkg::*;
#(
    parameter int CW = TDC_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic [CW-1:0] prim_o,
    output logic [CW-1:0] half_o,
    output logic          roll_o
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] prim;
        logic [CW-1:0] half;
        logic          roll;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (start_i) begin
            ctr_d = '0;
        end else begin
            ctr_d.prim = ctr_q.prim + 1'b1;
            ctr_d.half = ctr_q.prim;
            if (ctr_q.prim == TOP) ctr_d.roll = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign prim_o = ctr_q.prim;
    assign half_o = ctr_q.half;
    assign roll_o = ctr_q.roll;

    // R10: a start pulse leaves both counters and the wrap flag cleared
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (prim_o == '0 && half_o == '0 && !roll_o));

    // R7: the wrap edge lands on zero and raises the flag
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_o == TOP && !start_i) |=> (prim_o == '0 && roll_o));

    // R7: the wrap flag only falls through a start pulse
    p_roll_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_o && !start_i) |=> roll_o);
endmodule

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc
    import tdc_pkg::*;
#(
    parameter int N = TDC_TAPS,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] taps_i,
    output logic [W-1:0] code_o,
    output logic         err_o
);
    localparam int TW = N - 1;
    localparam logic [N-1:0] ONE = N'(1);

    logic [TW-1:0] edge_v;
    logic          multi;

    for (genvar g = 0; g < TW; g++) begin : g_edge
        assign edge_v[g] = taps_i[g] & ~taps_i[g+1];
    end

    always_comb begin
        code_o = '0;
        for (int i = TW - 1; i >= 0; i--) begin
            if (edge_v[i]) code_o = W'(i);
        end
        if (edge_v == '0 && (&taps_i)) code_o = W'(N - 1);
        multi = |(edge_v & (edge_v - TW'(1)));
        err_o = ~(taps_i[0] & ~taps_i[N-1] & (|edge_v) & ~multi);
    end

    // R4: an error-free code always describes a clean thermometer vector
    always_comb begin
        if (err_o == 1'b0) begin
            p_therm_shape_r4: assert (taps_i == ((ONE << (int'(code_o) + 1)) - ONE));
        end
    end
endmodule

// File: rtl/tdc_hit_queue.sv
module tdc_hit_queue
    import tdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                hit_i,
    input  logic [TDC_TAPS-1:0] taps_i,
    input  logic [TDC_CW-1:0]   prim_i,
    input  logic [TDC_CW-1:0]   half_i,
    output logic                stg_full_o,
    output hit_rec_t            stg_o,
    output logic                ovf_o
);
    typedef struct packed {
        hit_rec_t stg;
        hit_rec_t buff;
        logic     stg_full;
        logic     buf_full;
        logic     ovf;
    } q_t;

    q_t       q_d, q_q;
    hit_rec_t incoming;

    always_comb begin
        incoming = '{taps: taps_i, prim: prim_i, half: half_i};
        q_d = q_q;
        if (q_q.stg_full) begin
            q_d.stg_full = 1'b0;
            if (hit_i) begin
                if (q_q.buf_full) begin
                    q_d.ovf = 1'b1;
                end else begin
                    q_d.buff     = incoming;
                    q_d.buf_full = 1'b1;
                end
            end
        end else if (q_q.buf_full) begin
            q_d.stg      = q_q.buff;
            q_d.stg_full = 1'b1;
            if (hit_i) q_d.buff = incoming;
            else       q_d.buf_full = 1'b0;
        end else if (hit_i) begin
            q_d.stg      = incoming;
            q_d.stg_full = 1'b1;
        end
        if (start_i) q_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign stg_full_o = q_q.stg_full;
    assign stg_o      = q_q.stg;
    assign ovf_o      = q_q.ovf;

    // R8: the pending stage is never refilled on the edge that empties it
    p_no_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stg_full_o |=> !stg_full_o);

    // R9: a hit meeting a full stage and a full buffer raises overflow
    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.stg_full && q_q.buf_full && hit_i && !start_i) |=> ovf_o);

    // R9: overflow stays up until a start pulse
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !start_i) |=> ovf_o);
endmodule

// File: rtl/tdc_coarse_fine.sv
module tdc_coarse_fine
    import tdc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       hit_i,
    input  logic [TDC_TAPS-1:0]        taps_i,
    output logic [TDC_CW+TDC_FW-1:0]   time_o,
    output logic                       valid_o,
    output logic                       fine_err_o,
    output logic                       rollover_o,
    output logic                       overflow_o
);
    localparam logic [TDC_FW-1:0] MID = TDC_FW'(TDC_TAPS / 2);

    logic [TDC_CW-1:0] prim, half, coarse_sel;
    logic              roll, stg_full, ovf, enc_err;
    logic [TDC_FW-1:0] code;
    hit_rec_t          stg;
    result_t           res_d, res_q;

    tdc_coarse_ctr #(.CW(TDC_CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .prim_o (prim),
        .half_o (half),
        .roll_o (roll)
    );

    tdc_hit_queue u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .hit_i     (hit_i),
        .taps_i    (taps_i),
        .prim_i    (prim),
        .half_i    (half),
        .stg_full_o(stg_full),
        .stg_o     (stg),
        .ovf_o     (ovf)
    );

    tdc_therm_enc #(.N(TDC_TAPS), .W(TDC_FW)) u_enc (
        .taps_i(stg.taps),
        .code_o(code),
        .err_o (enc_err)
    );

    always_comb begin
        coarse_sel  = (code < MID) ? stg.half : stg.prim;
        res_d       = res_q;
        res_d.valid = stg_full;
        if (stg_full) begin
            res_d.tword = {coarse_sel, code};
            res_d.err   = enc_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign time_o     = res_q.tword;
    assign valid_o    = res_q.valid;
    assign fine_err_o = res_q.err;
    assign rollover_o = roll;
    assign overflow_o = ovf;

    // R6/R8: results are single-cycle strobes, never back to back
    p_valid_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: time word only changes together with a valid strobe
    p_word_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(time_o)));
endmodule

// File: tb/tdc_coarse_fine_bench.sv
module tdc_coarse_fine_bench;
    localparam int MASK = 32767;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hit_i = 1'b0;
    logic [31:0] taps_i = '0;
    logic [19:0] time_o;
    logic        valid_o, fine_err_o, rollover_o, overflow_o;

    int checks = 0;
    int errors = 0;
    int n_since = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdc_coarse_fine u_tdc_coarse_fine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .hit_i     (hit_i),
        .taps_i    (taps_i),
        .time_o    (time_o),
        .valid_o   (valid_o),
        .fine_err_o(fine_err_o),
        .rollover_o(rollover_o),
        .overflow_o(overflow_o)
    );

    task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (start_i) n_since = 0;
        else         n_since++;
        @(negedge clk);
    endtask

    task automatic do_start();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    // reference fine code: {err, code}
    function automatic logic [5:0] ref_fine(logic [31:0] t);
        logic [4:0] c = 5'd0;
        logic       found = 1'b0;
        logic       clean = 1'b0;
        for (int i = 0; i < 31; i++) begin
            if (!found && t[i] && !t[i+1]) begin
                c = 5'(i);
                found = 1'b1;
            end
        end
        if (!found) c = (t == 32'hFFFF_FFFF) ? 5'd31 : 5'd0;
        for (int k = 0; k < 31; k++) begin
            if ({32'd0, t} == ((64'd1 << (k + 1)) - 64'd1)) clean = 1'b1;
        end
        return {~clean, c};
    endfunction

    function automatic logic [14:0] ref_coarse(int n, logic [4:0] fine);
        if (fine < 5'd16) return (n >= 2) ? 15'((n - 2) & MASK) : 15'd0;
        return 15'((n - 1) & MASK);
    endfunction

    function automatic logic [31:0] therm(int k);
        return 32'((64'd1 << (k + 1)) - 64'd1);
    endfunction

    // one isolated hit, checked on the edge after the hit edge
    task automatic single(logic [31:0] t, string req);
        logic [5:0]  rf;
        logic [19:0] exp_word;
        hit_i  = 1'b1;
        taps_i = t;
        step();
        hit_i = 1'b0;
        rf = ref_fine(t);
        exp_word = {ref_coarse(n_since, rf[4:0]), rf[4:0]};
        expect_eq({req, " R6 no early valid"}, 32'(valid_o), 32'd0);
        step();
        expect_eq({req, " R6 valid"}, 32'(valid_o), 32'd1);
        expect_eq({req, " time word"}, 32'(time_o), 32'(exp_word));
        expect_eq({req, " err flag"}, 32'(fine_err_o), 32'(rf[5]));
    endtask

    initial begin
        logic [31:0] tq [4];
        int          nq [4];
        logic [5:0]  rf;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_eq("R1 time", 32'(time_o), 32'd0);
        expect_eq("R1 valid", 32'(valid_o), 32'd0);
        expect_eq("R1 flags", {29'd0, fine_err_o, rollover_o, overflow_o}, 32'd0);
        rst_n = 1'b1;
        step();
        do_start();

        // R3 boundary: hit one edge after start, early fine code
        single(therm(3), "R3 n=1");
        repeat (5) step();
        single(therm(20), "R2 late fine");
        repeat (3) step();
        single(therm(5), "R3 early fine");
        single(therm(15), "R3 fine=15");
        single(therm(16), "R2 fine=16");
        single(therm(0), "R4 k=0");
        single(therm(30), "R4 k=30");
        // R5 malformed vectors
        single(32'hFFFF_FFFF, "R5 all ones");
        single(32'h0000_0000, "R5 all zeros");
        single(32'h0000_00F5, "R5 bubbles");
        single(32'hFFFF_0000, "R5 no edge");
        single(32'h0000_0006, "R5 bit0 low");

        // random isolated hits
        for (int it = 0; it < 150; it++) begin
            logic [31:0] t;
            int gap;
            gap = int'($urandom % 7);
            for (int g = 0; g < gap; g++) step();
            if (($urandom % 4) != 0) t = therm(int'($urandom % 31));
            else                     t = $urandom;
            single(t, "R4/R5 random");
        end

        // R8/R9: four hits on consecutive edges
        do_start();
        repeat (10) step();
        for (int h = 0; h < 4; h++) begin
            tq[h] = therm(4 + 7 * h);
            hit_i = 1'b1;
            taps_i = tq[h];
            step();
            nq[h] = n_since;
            if (h == 0) expect_eq("R8 no valid on arrival", 32'(valid_o), 32'd0);
            if (h == 1) begin
                rf = ref_fine(tq[0]);
                expect_eq("R8 first result", 32'(time_o), 32'({ref_coarse(nq[0], rf[4:0]), rf[4:0]}));
                expect_eq("R8 first valid", 32'(valid_o), 32'd1);
            end
            if (h == 2) expect_eq("R8 gap", 32'(valid_o), 32'd0);
            if (h == 3) begin
                rf = ref_fine(tq[1]);
                expect_eq("R8 second result", 32'(time_o), 32'({ref_coarse(nq[1], rf[4:0]), rf[4:0]}));
                expect_eq("R8 second valid", 32'(valid_o), 32'd1);
                expect_eq("R9 overflow set", 32'(overflow_o), 32'd1);
            end
        end
        hit_i = 1'b0;
        step();
        expect_eq("R8 gap 2", 32'(valid_o), 32'd0);
        step();
        rf = ref_fine(tq[2]);
        expect_eq("R8 third valid", 32'(valid_o), 32'd1);
        expect_eq("R8 third result", 32'(time_o), 32'({ref_coarse(nq[2], rf[4:0]), rf[4:0]}));
        step();
        expect_eq("R9 dropped hit absent", 32'(valid_o), 32'd0);
        step();
        expect_eq("R9 dropped hit absent 2", 32'(valid_o), 32'd0);
        expect_eq("R9 overflow sticky", 32'(overflow_o), 32'd1);
        do_start();
        expect_eq("R10 overflow cleared", 32'(overflow_o), 32'd0);

        // R7 rollover
        while (n_since < 32767) step();
        expect_eq("R7 no rollover yet", 32'(rollover_o), 32'd0);
        step();
        expect_eq("R7 rollover set", 32'(rollover_o), 32'd1);
        single(therm(20), "R7 wrapped coarse");
        single(therm(2), "R7 wrapped trailing");
        expect_eq("R7 rollover sticky", 32'(rollover_o), 32'd1);
        do_start();
        expect_eq("R10 rollover cleared", 32'(rollover_o), 32'd0);
        single(therm(25), "R10 counter restarted");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule